// File: doc/BRIEF.md
# Gated Frequency Counter with Decimal Readout

This block measures the frequency of an external signal that runs with no relation to the reference clock. The reference clock sets the length of a counting window: one second at the default 50 MHz setting. Each rising transition of the external signal that falls inside the window is counted. At the end of the window the count is stored, the counter starts the next window in the following cycle, and the stored value is turned into decimal digits for a display.

The external signal first passes through a two-stage synchroniser. A rising transition is found by comparing the synchronised sample with the sample one cycle older. The stored binary count is converted to binary-coded decimal by a shift-and-add-three loop that handles one bit per cycle. When the conversion ends, the digit bus is updated and a valid strobe pulses for one cycle. A count above the largest value the digits can show makes every digit read nine.

Top module: `freq_meter`

## Requirements
- R1: While rst_ni is low, digits_o reads all zero and valid_o is low.
- R2: Only low-to-high transitions of sig_i are counted. A falling transition, or a level held for any time, adds nothing.
- R3: Each window is exactly GATE_CYCLES reference cycles long. Windows follow one another with no gap, so every detected transition is counted in exactly one window.
- R4: digits_o holds NUM_DIGITS BCD digits. Digit i sits at bits [4i+3:4i], digit 0 is the least significant, and each digit value lies in 0..9.
- R5: A window count above 10^NUM_DIGITS - 1 is shown with every digit equal to 9.
- R6: valid_o is high for exactly one cycle per window. It rises CNT_W+1 cycles after the final clock edge of that window, in the same cycle that digits_o takes the new value.
- R7: digits_o does not change in any cycle in which valid_o is low.
- R8: sig_i passes through two flops before transitions are detected. A pulse that is high for one reference cycle and low for at least one cycle still counts once.
- R9: A new conversion never starts while the previous one is still running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock that sets the window |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | External signal to be measured, asynchronous |
| digits_o | output | 4*NUM_DIGITS | BCD result, least significant digit in the low nibble |
| valid_o | output | 1 | One-cycle pulse marking a new result on digits_o |

## Verification
A wrong window counter or accumulator shows up as a wrong digit value at the next valid pulse, at most one window plus CNT_W+1 cycles after the fault. Errors of one transition at a window boundary show up the same way, because the reference model follows the synchroniser delay cycle by cycle. A fault in the conversion loop shows either wrong digits or a valid pulse on the wrong cycle. Both are visible as soon as that window's result appears. Digits that change without a strobe are caught in the very cycle they change.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Largest value NUM_DIGITS decimal digits can show: 10^digits - 1
    function automatic longint unsigned fc_max_value(int digits);
        longint unsigned r;
        r = 1;
        for (int i = 0; i < digits; i++) begin
            r = r * 10;
        end
        return r - 1;
    endfunction

endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = sig_i;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.last;

    // R8: a detected rise lasts a single cycle
    assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fc_gate_counter.sv
module fc_gate_counter #(
    parameter int GATE_CYCLES = 50_000_000,
    parameter int CNT_W       = 33
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic             start_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int GATE_W = $clog2(GATE_CYCLES);
    localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_CYCLES - 1);

    typedef struct packed {
        logic [GATE_W-1:0] gate;
        logic [CNT_W-1:0]  acc;
        logic [CNT_W-1:0]  count;
        logic              start;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.gate == GATE_LAST) begin
            st_d.gate  = '0;
            st_d.count = st_q.acc + CNT_W'(rise_i);
            st_d.acc   = '0;
            st_d.start = 1'b1;
        end else begin
            st_d.gate = st_q.gate + 1'b1;
            st_d.acc  = st_q.acc + CNT_W'(rise_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign count_o = st_q.count;

    // R3: window wraps after its last cycle and hands off a result
    assert_gate_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.gate == GATE_LAST) |=> (st_q.gate == '0 && start_o));
    // R3: accumulator never wraps inside a window
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.gate != GATE_LAST) |=> (st_q.acc >= $past(st_q.acc)));
    // R3: the handed-off count only moves with a start pulse
    assert_count_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_o |-> $stable(count_o));

endmodule

// File: rtl/fc_bcd_conv.sv
module fc_bcd_conv #(
    parameter int CNT_W      = 33,
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [CNT_W-1:0]        bin_i,
    output logic [4*NUM_DIGITS-1:0] digits_o,
    output logic                    valid_o
);
    localparam int BCD_W = 4 * NUM_DIGITS;
    localparam int SH_W  = BCD_W + CNT_W;
    localparam int IT_W  = $clog2(CNT_W);
    localparam logic [CNT_W-1:0] MAX_VAL = CNT_W'(fc_pkg::fc_max_value(NUM_DIGITS));
    localparam logic [IT_W-1:0]  IT_LAST = IT_W'(CNT_W - 1);

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [IT_W-1:0]  iter;
        logic             busy;
        logic [BCD_W-1:0] digits;
        logic             valid;
    } conv_t;

    conv_t            st_d, st_q;
    logic [SH_W-1:0]  adj;
    logic [SH_W-1:0]  shifted;
    logic [CNT_W-1:0] clipped;

    always_comb begin
        adj = st_q.sh;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (adj[CNT_W + 4*i +: 4] >= 4'd5) begin
                adj[CNT_W + 4*i +: 4] = adj[CNT_W + 4*i +: 4] + 4'd3;
            end
        end
        shifted = {adj[SH_W-2:0], 1'b0};
        clipped = (bin_i > MAX_VAL) ? MAX_VAL : bin_i;

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (start_i) begin
            st_d.sh   = {{BCD_W{1'b0}}, clipped};
            st_d.iter = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            st_d.sh   = shifted;
            st_d.iter = st_q.iter + 1'b1;
            if (st_q.iter == IT_LAST) begin
                st_d.busy   = 1'b0;
                st_d.digits = shifted[SH_W-1 -: BCD_W];
                st_d.valid  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign digits_o = st_q.digits;
    assign valid_o  = st_q.valid;

    // R9: a new value never arrives mid-conversion
    assert_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !st_q.busy);
    // R6: strobe lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);
    // R7: digits only move together with the strobe
    assert_digits_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(digits_o));

    // R4: each published digit is a legal BCD value
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit_chk
        assert_digit_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_o |-> (digits_o[4*g +: 4] <= 4'd9));
    end

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int GATE_CYCLES = 50_000_000,
    parameter int CNT_W       = 33,
    parameter int NUM_DIGITS  = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sig_i,
    output logic [4*NUM_DIGITS-1:0] digits_o,
    output logic                    valid_o
);
    logic             rise;
    logic             start;
    logic [CNT_W-1:0] count;

    fc_sync_edge i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    fc_gate_counter #(
        .GATE_CYCLES (GATE_CYCLES),
        .CNT_W       (CNT_W)
    ) i_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise),
        .start_o (start),
        .count_o (count)
    );

    fc_bcd_conv #(
        .CNT_W      (CNT_W),
        .NUM_DIGITS (NUM_DIGITS)
    ) i_conv (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .bin_i    (count),
        .digits_o (digits_o),
        .valid_o  (valid_o)
    );

    // R1: reset state at the ports
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (!valid_o && digits_o == '0));

endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
    localparam int GATE = 2400;
    localparam int CW   = 12;
    localparam int ND   = 3;
    localparam int LAT  = CW + 1;
    localparam int MAXV = 999;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig = 1'b0;
    logic [4*ND-1:0] digits;
    logic valid;

    always #2.5 clk = ~clk;

    freq_meter #(.GATE_CYCLES(GATE), .CNT_W(CW), .NUM_DIGITS(ND)) i_freq_meter (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .sig_i    (sig),
        .digits_o (digits),
        .valid_o  (valid)
    );

    int checks = 0;
    int fails = 0;
    int pos_k = 0;
    int nneg = 0;
    int gcount = 0;
    int acc = 0;
    int hist[4];
    int exp_val[$];
    int exp_due[$];
    bit rst_prev = 1'b0;
    bit sig_prev = 1'b0;
    string tag = "R3";
    logic [4*ND-1:0] last_exp = '0;

    function automatic logic [4*ND-1:0] to_bcd(int v);
        logic [4*ND-1:0] r;
        int x;
        x = (v > MAXV) ? MAXV : v;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // reference model, evaluated between clock edges
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) hist[i] = 0;
            gcount = 0; acc = 0;
            exp_val.delete(); exp_due.delete();
            last_exp = '0;
            if (nneg > 0) begin
                checks++;
                if (valid !== 1'b0 || digits !== '0) begin
                    fails++;
                    $display("FAIL R1 reset state: valid=%b digits=%h expected valid=0 digits=0", valid, digits);
                end
            end
        end else if (rst_prev) begin
            int rise;
            bit expv;
            pos_k++;
            hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
            hist[0] = int'(sig_prev);
            rise = (hist[2] == 1 && hist[3] == 0) ? 1 : 0;
            if (gcount == GATE - 1) begin
                exp_val.push_back(acc + rise);
                exp_due.push_back(pos_k + LAT);
                acc = 0; gcount = 0;
            end else begin
                acc += rise; gcount++;
            end
            expv = (exp_due.size() > 0 && exp_due[0] == pos_k);
            checks++;
            if (valid !== expv) begin
                fails++;
                $display("FAIL R6 strobe at cycle %0d: valid=%b expected %b", pos_k, valid, expv);
            end
            if (expv) begin
                logic [4*ND-1:0] ev;
                ev = to_bcd(exp_val[0]);
                checks++;
                if (digits !== ev) begin
                    fails++;
                    if (exp_val[0] > MAXV)
                        $display("FAIL R5 saturated result: digits=%h expected %h (count %0d)", digits, ev, exp_val[0]);
                    else
                        $display("FAIL %s R4 result: digits=%h expected %h (count %0d)", tag, digits, ev, exp_val[0]);
                end
                last_exp = ev;
                void'(exp_val.pop_front());
                void'(exp_due.pop_front());
            end else begin
                checks++;
                if (digits !== last_exp) begin
                    fails++;
                    $display("FAIL R7 digits moved without strobe: digits=%h expected %h", digits, last_exp);
                end
            end
        end
        rst_prev = rst_n;
        sig_prev = sig;
        nneg++;
    end

    task automatic wave(int hi, int lo, int total);
        for (int c = 0; c < total; c++) begin
            sig = ((c % (hi + lo)) < hi);
            @(posedge clk); #1;
        end
    endtask

    task automatic hold(logic v, int total);
        sig = v;
        repeat (total) begin @(posedge clk); #1; end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R3";  hold(1'b0, 2600);          // zero frequency
        tag = "R2";  hold(1'b1, 3000);          // one rise, long high level
        hold(1'b0, 200);
        tag = "R3";  wave(5, 5, 5000);          // period 10
        tag = "R5";  wave(1, 1, 5000);          // period 2, over range
        tag = "R8";  wave(1, 2, 5000);          // one-cycle pulses
        tag = "R3";  wave(3, 4, 3000);          // period 7
        rst_n = 1'b0;
        hold(1'b0, 5);
        rst_n = 1'b1;
        tag = "R1";  wave(2, 2, 3000);          // restart after reset
        hold(1'b0, 2700);
        finish_run();
    end

endmodule